// File: doc/BRIEF.md
# Register File with Aliased Special Registers

This block is the 64-entry, 16-bit working register file of a small processor core. Three of its entries also serve as special-purpose registers. Entry 0 is the accumulator, entry 62 holds the return address and entry 63 is the program counter. These three are not kept apart from the array. They are ordinary entries, so the processor can reach each of them by two routes: a dedicated load strobe, or the general indexed write port.

Every write takes its data from one shared 16-bit input bus. A single 6-bit index selects the target of a general write and also selects the entry shown on the combinational read port. The accumulator and the program counter each have a dedicated output that always shows their current contents. The return-address register has no dedicated output and can only be read through the index. Reset clears the array to zero, except for the program counter, which starts at a non-zero boot address.

Top module: `regbank_alias`

## Requirements
- R1: The array holds 2^6 = 64 entries of 16 bits. The 6-bit `sel` input chooses both the entry written by `gen_we` and the entry shown on `rd_q`.
- R2: A rising edge with `rst` high sets every entry to 0x0000, except entry 63, which is set to 0xA000. Reset is synchronous and active high.
- R3: A rising edge with `acc_ld` high loads `data_in` into entry 0. After that edge, both `acc_q` and `rd_q` with `sel`=0 show the new value.
- R4: A rising edge with `pc_ld` high loads `data_in` into entry 63. After that edge, both `pc_q` and `rd_q` with `sel`=63 show the new value.
- R5: A rising edge with `rpc_ld` high loads `data_in` into entry 62. The value can be read on `rd_q` with `sel`=62, and `pc_q` does not change.
- R6: A rising edge with `gen_we` high writes `data_in` into entry `sel`. Writing entry 0 updates `acc_q`, and writing entry 63 updates `pc_q`.
- R7: `rd_q` is combinational from `sel` and the stored contents. In the cycle after a write edge it already shows the new value.
- R8: The three dedicated load strobes ignore `sel`. A dedicated load changes only its own entry, whatever `sel` holds.
- R9: When several enables fire in one cycle and target different entries, every write takes effect. When a dedicated strobe and `gen_we` target the same entry, the dedicated strobe wins.
- R10: `rst` takes priority over every enable in the same cycle.
- R11: If no enable is high, every entry keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 16 | Shared write data |
| acc_ld | input | 1 | Load entry 0 (accumulator) |
| pc_ld | input | 1 | Load entry 63 (program counter) |
| rpc_ld | input | 1 | Load entry 62 (return address) |
| gen_we | input | 1 | General write to entry `sel` |
| sel | input | 6 | Entry index for general write and read |
| acc_q | output | 16 | Contents of entry 0 |
| pc_q | output | 16 | Contents of entry 63 |
| rd_q | output | 16 | Contents of entry `sel` |

## Verification
The assertions check the following on every cycle:
- the dedicated outputs after each kind of load;
- the reset values and reset priority;
- that `pc_q` does not move on a return-address load;
- that the outputs hold when the cycle is idle;
- that `rd_q` agrees with the dedicated outputs whenever `sel` points at entry 0 or entry 63.

Only the bench's scenarios can show the following:
- that the other 61 entries keep their values across the index sweeps;
- that dedicated loads leave the entry at `sel` untouched;
- that simultaneous writes to different entries all land.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  // Grouping of the three dedicated load strobes
  typedef struct packed {
    logic acc;
    logic rpc;
    logic pc;
  } ld_strobe_t;
endpackage

// File: rtl/regbank_wsel.sv
// Per-entry write enable from the dedicated strobes and the indexed write.
// All paths share one data bus, so only the enables need resolving.
module regbank_wsel
  import regbank_pkg::*;
#(
  parameter int AW = 6
) (
  input  ld_strobe_t            ld,
  input  logic                  gen_we,
  input  logic [AW-1:0]         sel,
  output logic [(1<<AW)-1:0]    we
);
  localparam int DEPTH   = 1 << AW;
  localparam int ACC_IDX = 0;
  localparam int RPC_IDX = DEPTH - 2;
  localparam int PC_IDX  = DEPTH - 1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    logic ded;
    if (i == ACC_IDX)      begin : g_acc assign ded = ld.acc; end
    else if (i == RPC_IDX) begin : g_rpc assign ded = ld.rpc; end
    else if (i == PC_IDX)  begin : g_pc  assign ded = ld.pc;  end
    else                   begin : g_gp  assign ded = 1'b0;   end
    assign we[i] = ded | (gen_we & (sel == AW'(i)));
  end
endmodule

// File: rtl/regbank_cell.sv
// One storage entry with its own reset value.
module regbank_cell #(
  parameter int          DW      = 16,
  parameter logic [15:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= DW'(RST_VAL);
    else if (we) q <= d;
  end
endmodule

// File: rtl/regbank_rdmux.sv
// Combinational indexed read.
module regbank_rdmux #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic [(1<<AW)-1:0][DW-1:0] regs,
  input  logic [AW-1:0]              sel,
  output logic [DW-1:0]              rd
);
  assign rd = regs[sel];
endmodule

// File: rtl/regbank_alias.sv
module regbank_alias
  import regbank_pkg::*;
#(
  parameter int          DW     = 16,
  parameter int          AW     = 6,
  parameter logic [15:0] PC_RST = 16'hA000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] data_in,
  input  logic          acc_ld,
  input  logic          pc_ld,
  input  logic          rpc_ld,
  input  logic          gen_we,
  input  logic [AW-1:0] sel,
  output logic [DW-1:0] acc_q,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] rd_q
);
  localparam int DEPTH   = 1 << AW;
  localparam int ACC_IDX = 0;
  localparam int PC_IDX  = DEPTH - 1;

  ld_strobe_t                  ld;
  logic [DEPTH-1:0]            we;
  logic [DEPTH-1:0][DW-1:0]    regs;

  assign ld = '{acc: acc_ld, rpc: rpc_ld, pc: pc_ld};

  regbank_wsel #(.AW(AW)) wsel_i (
    .ld     (ld),
    .gen_we (gen_we),
    .sel    (sel),
    .we     (we)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [15:0] RV = (i == PC_IDX) ? PC_RST : 16'h0000;
    regbank_cell #(.DW(DW), .RST_VAL(RV)) cell_i (
      .clk (clk),
      .rst (rst),
      .we  (we[i]),
      .d   (data_in),
      .q   (regs[i])
    );
  end

  regbank_rdmux #(.DW(DW), .AW(AW)) rdmux_i (
    .regs (regs),
    .sel  (sel),
    .rd   (rd_q)
  );

  assign acc_q = regs[ACC_IDX];
  assign pc_q  = regs[PC_IDX];
endmodule

// File: rtl/regbank_alias_chk.sv
module regbank_alias_chk #(
  parameter int          DW     = 16,
  parameter int          AW     = 6,
  parameter logic [15:0] PC_RST = 16'hA000
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] data_in,
  input logic          acc_ld,
  input logic          pc_ld,
  input logic          rpc_ld,
  input logic          gen_we,
  input logic [AW-1:0] sel,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] rd_q
);
  localparam logic [AW-1:0] PC_SEL = {AW{1'b1}};

  // R2 R10
  reset_vals_chk: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && (pc_q == DW'(PC_RST)));

  // R3
  acc_load_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ld |=> acc_q == $past(data_in));

  // R4
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    pc_ld |=> pc_q == $past(data_in));

  // R5
  rpc_keeps_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (rpc_ld && !pc_ld && !(gen_we && sel == PC_SEL)) |=> $stable(pc_q));

  // R6
  gen_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_we && sel == '0) |=> acc_q == $past(data_in));

  // R6
  gen_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_we && sel == PC_SEL) |=> pc_q == $past(data_in));

  // R7
  rd_acc_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> rd_q == acc_q);

  // R7
  rd_pc_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == PC_SEL) |-> rd_q == pc_q);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_ld || pc_ld || rpc_ld || gen_we) |=> $stable(acc_q) && $stable(pc_q));
endmodule

bind regbank_alias regbank_alias_chk #(.DW(DW), .AW(AW), .PC_RST(PC_RST)) chk_i (.*);

// File: tb/regbank_alias_tb_top.sv
module regbank_alias_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, acc_ld, pc_ld, rpc_ld, gen_we;
  logic [15:0] data_in;
  logic [5:0]  sel;
  logic [15:0] acc_q, pc_q, rd_q;

  int          n_vec  = 0;
  int          n_fail = 0;
  bit          mdl_ok = 0;
  logic [15:0] mdl [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_alias dut_i (
    .clk(clk), .rst(rst), .data_in(data_in), .acc_ld(acc_ld), .pc_ld(pc_ld),
    .rpc_ld(rpc_ld), .gen_we(gen_we), .sel(sel),
    .acc_q(acc_q), .pc_q(pc_q), .rd_q(rd_q)
  );

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive on the falling edge, check read before the edge,
  // update the reference, and check all outputs after the edge.
  task automatic step(string tag, bit r, bit a, bit p, bit rp, bit g,
                      int s, logic [15:0] d);
    @(negedge clk);
    rst = r; acc_ld = a; pc_ld = p; rpc_ld = rp; gen_we = g;
    sel = 6'(s); data_in = d;
    #1;
    if (mdl_ok) cmp({tag, " R7 pre-edge rd_q"}, rd_q, mdl[s]);
    @(posedge clk);
    if (r) begin
      foreach (mdl[k]) mdl[k] = 16'h0000;
      mdl[63] = 16'hA000;
      mdl_ok = 1;
    end else begin
      if (g)  mdl[s]  = d;
      if (a)  mdl[0]  = d;
      if (rp) mdl[62] = d;
      if (p)  mdl[63] = d;
    end
    #1;
    cmp({tag, " acc_q"}, acc_q, mdl[0]);
    cmp({tag, " pc_q"},  pc_q,  mdl[63]);
    cmp({tag, " R7 rd_q"}, rd_q, mdl[s]);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 64; i++) step(tag, 0, 0, 0, 0, 0, i, 16'hFFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    // R2 reset values, then R1 sweep of the whole array
    step("R2 reset", 1, 0, 0, 0, 0, 0, 16'hFFFF);
    step("R2 reset hold", 1, 0, 0, 0, 0, 63, 16'hFFFF);
    sweep("R1 R2 after reset");
    // R3 R8 accumulator load with sel elsewhere
    step("R3 R8 acc load", 0, 1, 0, 0, 0, 42, 16'hC3C3);
    sweep("R3 R8 sweep");
    // R4 R8 program counter load
    step("R4 R8 pc load", 0, 0, 1, 0, 0, 21, 16'h3C3C);
    sweep("R4 sweep");
    // R5 return address load; pc unchanged
    step("R5 rpc load", 0, 0, 0, 1, 0, 51, 16'h9696);
    step("R5 read 62", 0, 0, 0, 0, 0, 62, 16'h0000);
    // R6 general writes in interleaved order, reaching 0 and 63
    for (int i = 0; i < 64; i++)
      step("R6 gen write", 0, 0, 0, 0, 1, (i % 32) * 2 + i / 32,
           {~8'(i), 8'(i)});
    sweep("R6 R1 sweep");
    // R9 simultaneous writes to different entries
    step("R9 acc+pc+rpc+gen", 0, 1, 1, 1, 1, 17, 16'h1234);
    step("R9 read 17", 0, 0, 0, 0, 0, 17, 16'h0000);
    step("R9 read 62", 0, 0, 0, 0, 0, 62, 16'h0000);
    // R9 same-entry conflict: dedicated and general to entry 0
    step("R9 acc+gen same", 0, 1, 0, 0, 1, 0, 16'hBEEF);
    step("R9 pc+gen same", 0, 0, 1, 0, 1, 63, 16'h5A5A);
    // R10 reset beats every enable
    step("R10 rst over enables", 1, 1, 1, 1, 1, 5, 16'h7777);
    step("R10 read 5", 0, 0, 0, 0, 0, 5, 16'h0000);
    step("R10 read 62", 0, 0, 0, 0, 0, 62, 16'h0000);
    // R11 idle cycles hold everything, data bus toggling
    step("R11 load", 0, 0, 0, 0, 1, 9, 16'hAAAA);
    for (int i = 0; i < 8; i++)
      step("R11 idle", 0, 0, 0, 0, 0, 9, 16'(i * 16'h1111));
    sweep("R11 sweep");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule